// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Read Cache

This block is a direct-mapped read cache for a processor. Its tag array keeps only the low `RTAG_W` bits of each line's tag. The upper part of the tag is held once, in a single shared register called the locality register, because most references in an embedded workload stay inside one large address region. Every request first compares its upper tag bits with the locality register. The short per-line tag is consulted only when that comparison succeeds, so a short-tag match can never be a false hit.

A request whose upper bits differ from the locality register goes straight to the backing memory. Its word is returned, and no cache line is disturbed. A small detector counts consecutive requests of this kind that share the same upper bits. When it has seen `REPEAT` of them, it loads that value into the locality register and invalidates every line in the same cycle.

The controller is a four-state machine:
- `ST_IDLE` accepts a request (IDLE→PROBE).
- `ST_PROBE` performs the split comparison. It has three exits: a hit returns data (PROBE→IDLE), a short-tag miss fills the line (PROBE→FILL), and a locality miss bypasses the cache (PROBE→BYPASS).
- `ST_FILL` and `ST_BYPASS` each wait for the memory's line response, then return to IDLE.

Top module: `ltc_top`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `mem_req_valid` are 0, every line is invalid, and the locality register holds 0.
- R2: An accepted request whose upper tag bits (address bits above the index and the low `RTAG_W` tag bits) differ from the locality register raises `ev_ovf_miss` in the cycle after acceptance and never raises `ev_hit`, whatever the short tag stored at its index.
- R3: When the locality register matches, the indexed line is valid and its stored short tag equals the address's low `RTAG_W` tag bits, `ev_hit` and `resp_valid` rise in the cycle after acceptance, carry the word, and no memory request is made.
- R4: When the locality register matches but the line is invalid or its short tag differs, `ev_rtag_miss` pulses. The line-aligned address is requested from memory, the returned line is written into the indexed entry and marked valid, and the requested word is returned in the cycle the memory responds.
- R5: A locality-miss request fetches the line from memory and returns the word without changing any cache entry.
- R6: When `REPEAT` consecutive locality misses carry the same upper tag value, `ev_reload` pulses together with `ev_ovf_miss` on the last of them, and the locality register takes that value.
- R7: A locality hit clears the consecutive-miss count, and a locality miss with a different upper value restarts the count at 1.
- R8: A reload invalidates every line in the same cycle.
- R9: At most one request is outstanding: `req_ready` is 0 from acceptance until the response, and `mem_req_valid` stays high until `mem_resp_valid`.
- R10: The returned word is the `WORD_W`-bit slice of the line chosen by the address bits just above the byte offset. Word 0 is the least-significant slice of the line data.
- R11: Each accepted request raises exactly one of `ev_hit`, `ev_ovf_miss` and `ev_rtag_miss`, once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | ADDR_W | Byte address of the read |
| resp_valid | output | 1 | Read data valid pulse |
| resp_data | output | WORD_W | Read data |
| mem_req_valid | output | 1 | Line fetch request, held until answered |
| mem_req_addr | output | ADDR_W | Line-aligned fetch address |
| mem_resp_valid | input | 1 | Line data from memory valid |
| mem_resp_data | input | LINE_BYTES*8 | Line data, word 0 least significant |
| ev_hit | output | 1 | Full hit pulse |
| ev_ovf_miss | output | 1 | Locality mismatch pulse |
| ev_rtag_miss | output | 1 | Locality match with short-tag miss pulse |
| ev_reload | output | 1 | Locality register reload pulse |

## Verification
The bench builds the cache with 16 lines of 8 bytes, a 2-bit short tag and a reload threshold of 3. With only 16 lines, random addresses drawn from a few upper tag values and four short tag values keep hitting aliased lines, locality switches and reloads. A full-tag reference model in the bench flags any hit that a short tag alone would wrongly report. Directed sequences cover a bypass that leaves the filled line intact, a count interrupted by a locality hit, and the flush that follows a reload.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROBE,
        ST_FILL,
        ST_BYPASS
    } ltc_state_e;
endpackage

// File: rtl/ltc_locality.sv
module ltc_locality #(
    parameter int UP_W   = 17,
    parameter int REPEAT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            probe_en,
    input  logic [UP_W-1:0] probe_up,
    output logic            ovf_hit,
    output logic            reload
);
    localparam int CNT_W = $clog2(REPEAT + 1);

    logic [UP_W-1:0]  buf_q;
    logic [UP_W-1:0]  cand_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             same_run;

    assign ovf_hit  = (probe_up == buf_q);
    assign same_run = (cnt_q != '0) && (probe_up == cand_q);
    assign cnt_next = same_run ? cnt_q + 1'b1 : CNT_W'(1);
    assign reload   = probe_en && !ovf_hit && (cnt_next == CNT_W'(REPEAT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            cand_q <= '0;
            cnt_q  <= '0;
        end else if (probe_en) begin
            if (ovf_hit) begin
                cnt_q <= '0;
            end else if (reload) begin
                buf_q <= probe_up;
                cnt_q <= '0;
            end else begin
                cand_q <= probe_up;
                cnt_q  <= cnt_next;
            end
        end
    end

    // R6
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (buf_q == $past(probe_up)));
endmodule

// File: rtl/ltc_store.sv
module ltc_store #(
    parameter int LINES  = 1024,
    parameter int RTAG_W = 4,
    parameter int LINE_W = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] idx,
    output logic                     rd_valid,
    output logic [RTAG_W-1:0]        rd_rtag,
    output logic [LINE_W-1:0]        rd_data,
    input  logic                     wr_en,
    input  logic [RTAG_W-1:0]        wr_rtag,
    input  logic [LINE_W-1:0]        wr_data,
    input  logic                     flush
);
    logic [LINES-1:0]  valid_q;
    logic [RTAG_W-1:0] rtag_q [LINES];
    logic [LINE_W-1:0] data_q [LINES];

    assign rd_valid = valid_q[idx];
    assign rd_rtag  = rtag_q[idx];
    assign rd_data  = data_q[idx];

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            rtag_q[idx] <= wr_rtag;
            data_q[idx] <= wr_data;
        end
    end

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
endmodule

// File: rtl/ltc_ctrl.sv
module ltc_ctrl
    import ltc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINES      = 1024,
    parameter int LINE_BYTES = 8,
    parameter int WORD_W     = 32,
    parameter int RTAG_W     = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [ADDR_W-1:0]              req_addr,
    output logic                           resp_valid,
    output logic [WORD_W-1:0]              resp_data,
    output logic                           mem_req_valid,
    output logic [ADDR_W-1:0]              mem_req_addr,
    input  logic                           mem_resp_valid,
    input  logic [LINE_BYTES*8-1:0]        mem_resp_data,
    output logic                           probe_en,
    output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(LINES)-RTAG_W-1:0] probe_up,
    input  logic                           ovf_hit,
    output logic [$clog2(LINES)-1:0]       idx,
    input  logic                           line_valid,
    input  logic [RTAG_W-1:0]              line_rtag,
    input  logic [LINE_BYTES*8-1:0]        line_data,
    output logic                           fill_we,
    output logic [RTAG_W-1:0]              fill_rtag,
    output logic                           ev_hit,
    output logic                           ev_ovf_miss,
    output logic                           ev_rtag_miss
);
    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int IDX_W    = $clog2(LINES);
    localparam int LINE_W   = LINE_BYTES * 8;
    localparam int WORDS    = LINE_W / WORD_W;
    localparam int BYTE_OFF = $clog2(WORD_W / 8);
    localparam int WSEL_W   = (WORDS > 1) ? $clog2(WORDS) : 1;

    ltc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] line_words [WORDS];
    logic [WORD_W-1:0] mem_words  [WORDS];
    logic [WSEL_W-1:0] wsel;
    logic              line_hit;
    logic              unused_bits;

    for (genvar w = 0; w < WORDS; w++) begin : g_words
        assign line_words[w] = line_data[w*WORD_W +: WORD_W];
        assign mem_words[w]  = mem_resp_data[w*WORD_W +: WORD_W];
    end

    assign probe_up     = addr_q[ADDR_W-1 -: $bits(probe_up)];
    assign fill_rtag    = addr_q[OFF_W+IDX_W +: RTAG_W];
    assign idx          = addr_q[OFF_W +: IDX_W];
    assign wsel         = (WORDS > 1) ? addr_q[BYTE_OFF +: WSEL_W] : '0;
    assign line_hit     = line_valid && (line_rtag == fill_rtag);
    assign mem_req_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign unused_bits  = ^addr_q[BYTE_OFF-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) addr_q <= req_addr;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_PROBE;
            ST_PROBE:  if (!ovf_hit) state_d = ST_BYPASS;
                       else if (line_hit) state_d = ST_IDLE;
                       else state_d = ST_FILL;
            ST_FILL,
            ST_BYPASS: if (mem_resp_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready     = 1'b0;
        resp_valid    = 1'b0;
        resp_data     = '0;
        mem_req_valid = 1'b0;
        probe_en      = 1'b0;
        fill_we       = 1'b0;
        ev_hit        = 1'b0;
        ev_ovf_miss   = 1'b0;
        ev_rtag_miss  = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_PROBE: begin
                probe_en = 1'b1;
                if (!ovf_hit) begin
                    ev_ovf_miss = 1'b1;
                end else if (line_hit) begin
                    ev_hit     = 1'b1;
                    resp_valid = 1'b1;
                    resp_data  = line_words[wsel];
                end else begin
                    ev_rtag_miss = 1'b1;
                end
            end
            ST_FILL, ST_BYPASS: begin
                mem_req_valid = 1'b1;
                if (mem_resp_valid) begin
                    resp_valid = 1'b1;
                    resp_data  = mem_words[wsel];
                    fill_we    = (state_q == ST_FILL);
                end
            end
            default: ;
        endcase
    end

    // R11
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_hit, ev_ovf_miss, ev_rtag_miss}));
    // R9
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
    // R4
    rtag_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rtag_miss |=> mem_req_valid);
    // R3
    hit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit |=> req_ready);
endmodule

// File: rtl/ltc_top.sv
module ltc_top #(
    parameter int ADDR_W     = 32,
    parameter int LINES      = 1024,
    parameter int LINE_BYTES = 8,
    parameter int WORD_W     = 32,
    parameter int RTAG_W     = 4,
    parameter int REPEAT     = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    resp_valid,
    output logic [WORD_W-1:0]       resp_data,
    output logic                    mem_req_valid,
    output logic [ADDR_W-1:0]       mem_req_addr,
    input  logic                    mem_resp_valid,
    input  logic [LINE_BYTES*8-1:0] mem_resp_data,
    output logic                    ev_hit,
    output logic                    ev_ovf_miss,
    output logic                    ev_rtag_miss,
    output logic                    ev_reload
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int UP_W   = ADDR_W - OFF_W - IDX_W - RTAG_W;
    localparam int LINE_W = LINE_BYTES * 8;

    logic              probe_en, ovf_hit, line_valid, fill_we;
    logic [UP_W-1:0]   probe_up;
    logic [IDX_W-1:0]  idx;
    logic [RTAG_W-1:0] line_rtag, fill_rtag;
    logic [LINE_W-1:0] line_data;

    ltc_ctrl #(
        .ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES),
        .WORD_W(WORD_W), .RTAG_W(RTAG_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .probe_en(probe_en), .probe_up(probe_up), .ovf_hit(ovf_hit),
        .idx(idx), .line_valid(line_valid), .line_rtag(line_rtag),
        .line_data(line_data), .fill_we(fill_we), .fill_rtag(fill_rtag),
        .ev_hit(ev_hit), .ev_ovf_miss(ev_ovf_miss), .ev_rtag_miss(ev_rtag_miss)
    );

    ltc_locality #(.UP_W(UP_W), .REPEAT(REPEAT)) u_loc (
        .clk(clk), .rst_n(rst_n), .probe_en(probe_en), .probe_up(probe_up),
        .ovf_hit(ovf_hit), .reload(ev_reload)
    );

    ltc_store #(.LINES(LINES), .RTAG_W(RTAG_W), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .idx(idx),
        .rd_valid(line_valid), .rd_rtag(line_rtag), .rd_data(line_data),
        .wr_en(fill_we), .wr_rtag(fill_rtag), .wr_data(mem_resp_data),
        .flush(ev_reload)
    );
endmodule

// File: tb/tb_ltc_top.sv
module tb_ltc_top;
    localparam int ADDR_W = 32, LINES = 16, LINE_BYTES = 8, WORD_W = 32;
    localparam int RTAG_W = 2, REPEAT = 3;
    localparam int UP_W = 23;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, mem_resp_valid = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0] mem_resp_data = '0;
    logic req_ready, resp_valid, mem_req_valid;
    logic [WORD_W-1:0] resp_data;
    logic [ADDR_W-1:0] mem_req_addr;
    logic ev_hit, ev_ovf_miss, ev_rtag_miss, ev_reload;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [UP_W-1:0] m_buf, m_cand;
    int m_cnt;
    bit m_val [LINES];
    logic [24:0] m_tag [LINES];

    always #10 clk = ~clk;

    ltc_top #(.ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES),
              .WORD_W(WORD_W), .RTAG_W(RTAG_W), .REPEAT(REPEAT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .ev_hit(ev_hit), .ev_ovf_miss(ev_ovf_miss), .ev_rtag_miss(ev_rtag_miss),
        .ev_reload(ev_reload));

    function automatic logic [31:0] word_of(logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [63:0] line_of(logic [31:0] a);
        return {word_of({a[31:3], 3'b100}), word_of({a[31:3], 3'b000})};
    endfunction

    function automatic logic [31:0] mk(int up, int rt, int ix, int w);
        return {UP_W'(up), RTAG_W'(rt), 4'(ix), 1'(w), 2'b00};
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(logic [31:0] a);
        logic [UP_W-1:0] up;
        int ix;
        bit e_hit, e_ovf, e_rt, e_rl;
        string tag;
        up = a[31:9];
        ix = int'(a[6:3]);
        e_hit = 0; e_ovf = 0; e_rt = 0; e_rl = 0;
        if (up == m_buf) begin
            m_cnt = 0;
            if (m_val[ix] && m_tag[ix] == a[31:7]) e_hit = 1; else e_rt = 1;
        end else begin
            e_ovf = 1;
            if (m_cnt != 0 && up == m_cand) m_cnt++; else begin m_cand = up; m_cnt = 1; end
            if (m_cnt == REPEAT) begin e_rl = 1; m_cnt = 0; end
        end
        tag = e_hit ? "R3" : (e_rt ? "R4" : (e_rl ? "R6" : "R2"));
        @(negedge clk);
        chk(req_ready, "R9 ready before request", req_ready, 1);
        req_valid = 1; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        chk({ev_hit, ev_ovf_miss, ev_rtag_miss, ev_reload} == {e_hit, e_ovf, e_rt, e_rl},
            {tag, " R11 events"}, {ev_hit, ev_ovf_miss, ev_rtag_miss, ev_reload},
            {e_hit, e_ovf, e_rt, e_rl});
        if (e_hit) begin
            chk(resp_valid && resp_data == word_of(a), "R3 R10 hit data", resp_data, word_of(a));
            chk(!mem_req_valid, "R3 no memory request", mem_req_valid, 0);
        end else begin
            @(negedge clk);
            chk(mem_req_valid && mem_req_addr == {a[31:3], 3'b000}, {tag, " fetch address"},
                mem_req_addr, {a[31:3], 3'b000});
            repeat ($urandom_range(0, 2)) begin
                chk(!req_ready && mem_req_valid && !resp_valid, "R9 busy while fetching",
                    {req_ready, mem_req_valid, resp_valid}, 3'b010);
                @(negedge clk);
            end
            mem_resp_valid = 1; mem_resp_data = line_of(a);
            #1;
            chk(resp_valid && resp_data == word_of(a), {tag, " R10 fetched word"},
                resp_data, word_of(a));
            @(negedge clk);
            mem_resp_valid = 0; mem_resp_data = '0;
            if (e_rt) begin m_val[ix] = 1; m_tag[ix] = a[31:7]; end
        end
        if (e_rl) begin
            m_buf = up;
            for (int i = 0; i < LINES; i++) m_val[i] = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_buf = '0; m_cand = '0; m_cnt = 0;
        for (int i = 0; i < LINES; i++) begin m_val[i] = 0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !resp_valid && !mem_req_valid, "R1 reset outputs",
            {req_ready, resp_valid, mem_req_valid}, 3'b100);
        access(mk(0, 1, 5, 0));   // R1 R4 empty line, locality 0
        access(mk(0, 1, 5, 1));   // R3 R10 upper word
        access(mk(0, 1, 5, 0));   // R10 lower word
        access(mk(0, 2, 5, 0));   // R4 short tag conflict
        access(mk(0, 2, 5, 1));
        // R5 bypass leaves line intact; R2 same short tag other locality
        access(mk(7, 2, 5, 0));
        access(mk(0, 2, 5, 1));   // must still hit
        // R7 count broken by a locality hit, then by another upper value
        access(mk(9, 0, 1, 0));
        access(mk(9, 0, 2, 0));
        access(mk(0, 2, 5, 0));
        access(mk(9, 0, 3, 0));
        access(mk(8, 0, 3, 0));
        access(mk(9, 0, 4, 0));
        access(mk(9, 0, 4, 1));
        access(mk(9, 1, 4, 1));   // R6 reload on third
        // R8 previous lines flushed
        access(mk(0, 2, 5, 1));
        access(mk(9, 2, 5, 1));
        access(mk(9, 2, 5, 0));
        for (int n = 0; n < 600; n++) begin
            int ups [3] = '{9, 0, 3};
            access(mk(ups[$urandom_range(0, 2)], $urandom_range(0, 3),
                      $urandom_range(0, 15), $urandom_range(0, 1)));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule